// File: doc/BRIEF.md
# Coin Value Display Sequencer

This block turns the three level bits produced by an analog coin sensor's comparator bank into a two-digit cent value. It shows that value on two common-anode seven-segment digits. The level bits form a thermometer code: each bit is set when the sensed peak crosses a higher threshold. A coin arrives asynchronously to the clock, so the bits are first synchronized.

A rising edge on the lowest level bit starts a sequence. During a hold interval the display shows the coin value. Because the analog level may still be rising just after the trigger, the largest value seen during the hold is kept. When the hold ends, a clear interval drives a reset output that discharges the external peak detector, and the value stays on the display. After the clear interval the display returns to 00 and the block is ready again. Both interval lengths are set in milliseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `coin_display_seq`

## Requirements
- R1: After reset, busy and peak_clr are 0, both BCD nibbles are 0 and both segment buses show the digit 0.
- R2: The level bits `level_i[2:0]` are read as a thermometer code. 001 is a 5-cent coin, shown as tens 0 and units 5. 011 is 10 cents, shown as tens 1 and units 0. 111 is 25 cents, shown as tens 2 and units 5. 000 is no coin.
- R3: A non-thermometer code is valued by counting only the contiguous ones starting at bit 0. For example 101 is valued as 5 cents, and 110, 100 and 010 are valued as no coin.
- R4: A sequence starts only on a 0-to-1 change of bit 0 after synchronization. Busy rises on the third rising clock edge after the input change, and a level held high starts nothing further.
- R5: The hold interval lasts exactly HOLD_MS*CLK_HZ/1000 cycles. During it busy is 1, peak_clr is 0 and the coin value is shown.
- R6: The clear interval follows the hold at once and lasts exactly CLR_MS*CLK_HZ/1000 cycles. During it peak_clr and busy are 1 and the value stays on the display.
- R7: When the clear interval ends, busy and peak_clr fall together and the display returns to 00.
- R8: Busy is 1 for the whole sequence, hold and clear, and peak_clr is never 1 without busy.
- R9: Rising edges of bit 0 during a sequence are ignored and do not restart or lengthen it.
- R10: During the hold interval the displayed value is the largest coin value decoded since the trigger, and it never decreases.
- R11: Segment buses are active-low, with bit order {g,f,e,d,c,b,a}. The digit 0 is 7'h40, 1 is 7'h79, 2 is 7'h24 and 5 is 7'h12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_i | input | 3 | Comparator level bits, asynchronous |
| bcd_tens | output | 4 | Tens digit in BCD |
| bcd_units | output | 4 | Units digit in BCD |
| seg_tens_n | output | 7 | Active-low segments of the tens digit, {g..a} |
| seg_units_n | output | 7 | Active-low segments of the units digit, {g..a} |
| busy | output | 1 | A sequence is running |
| peak_clr | output | 1 | Reset pulse for the external peak detector |

## Verification
A wrong sequencer state or counter shows at the ports at once, through busy and peak_clr. A sequence that is too short, too long, restarted or split differs from the expected cycle count at the first sample past the expected boundary. A corrupted captured coin value shows as a wrong nibble or segment pattern one cycle after it is written. That wrong value persists until the sequence ends. A synchronizer or edge-detect fault shifts the start of busy away from the third edge, or makes a held level start a second sequence.

// File: rtl/coin_pkg.sv
package coin_pkg;
   typedef enum logic [1:0] {
      COIN_NONE    = 2'd0,
      COIN_NICKEL  = 2'd1,
      COIN_DIME    = 2'd2,
      COIN_QUARTER = 2'd3
   } coin_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_HOLD  = 2'd1,
      SEQ_CLEAR = 2'd2
   } seq_e;

   // count contiguous ones from bit 0 of the level
   function automatic coin_e coin_from_level(input logic [2:0] lvl);
      coin_e c;
      if (!lvl[0])      c = COIN_NONE;
      else if (!lvl[1]) c = COIN_NICKEL;
      else if (!lvl[2]) c = COIN_DIME;
      else              c = COIN_QUARTER;
      return c;
   endfunction
endpackage

// File: rtl/coin_level_sync.sv
module coin_level_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o,
   output logic             rise0_o
);
   logic [WIDTH-1:0] chain_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("coin_level_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= raw_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
         prev_q <= chain_q[STAGES-1];
      end
   end

   assign sync_o  = chain_q[STAGES-1];
   assign rise0_o = chain_q[STAGES-1][0] & ~prev_q[0];
endmodule

// File: rtl/coin_seq_ctrl.sv
module coin_seq_ctrl
   import coin_pkg::*;
#(
   parameter int HOLD_CYC = 100,
   parameter int CLR_CYC  = 50
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  start_i,
   input  coin_e coin_i,
   output coin_e shown_o,
   output logic  busy_o,
   output logic  clr_o
);
   localparam int MAX_CYC = (HOLD_CYC > CLR_CYC) ? HOLD_CYC : CLR_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   seq_e             state_q;
   logic [CNT_W-1:0] cnt_q;
   coin_e            shown_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         shown_q <= COIN_NONE;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  state_q <= SEQ_HOLD;
                  cnt_q   <= CNT_W'(HOLD_CYC - 1);
                  shown_q <= coin_i;
               end
            end
            SEQ_HOLD: begin
               if (coin_i > shown_q) shown_q <= coin_i;
               if (cnt_q == '0) begin
                  state_q <= SEQ_CLEAR;
                  cnt_q   <= CNT_W'(CLR_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SEQ_CLEAR: begin
               if (cnt_q == '0) begin
                  state_q <= SEQ_IDLE;
                  shown_q <= COIN_NONE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign shown_o = shown_q;
   assign busy_o  = (state_q != SEQ_IDLE);
   assign clr_o   = (state_q == SEQ_CLEAR);
endmodule

// File: rtl/coin_seg_enc.sv
module coin_seg_enc (
   input  logic [3:0] bcd_i,
   output logic [6:0] seg_n_o
);
   logic [6:0] lit;   // {g,f,e,d,c,b,a}, 1 = segment on

   always_comb begin
      case (bcd_i)
         4'd0:    lit = 7'b0111111;
         4'd1:    lit = 7'b0000110;
         4'd2:    lit = 7'b1011011;
         4'd3:    lit = 7'b1001111;
         4'd4:    lit = 7'b1100110;
         4'd5:    lit = 7'b1101101;
         4'd6:    lit = 7'b1111101;
         4'd7:    lit = 7'b0000111;
         4'd8:    lit = 7'b1111111;
         4'd9:    lit = 7'b1101111;
         default: lit = 7'b1000000;
      endcase
   end

   assign seg_n_o = ~lit;
endmodule

// File: rtl/coin_display_seq.sv
module coin_display_seq
   import coin_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int HOLD_MS     = 1850,
   parameter int CLR_MS      = 840,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [2:0] level_i,
   output logic [3:0] bcd_tens,
   output logic [3:0] bcd_units,
   output logic [6:0] seg_tens_n,
   output logic [6:0] seg_units_n,
   output logic       busy,
   output logic       peak_clr
);
   localparam int CYC_PER_MS = CLK_HZ / 1000;
   localparam int HOLD_CYC   = CYC_PER_MS * HOLD_MS;
   localparam int CLR_CYC    = CYC_PER_MS * CLR_MS;

   generate
      if (CYC_PER_MS < 1) begin : g_bad_clk
         $error("coin_display_seq: CLK_HZ must be at least 1000");
      end
      if (HOLD_MS < 1 || CLR_MS < 1) begin : g_bad_len
         $error("coin_display_seq: interval lengths must be positive");
      end
   endgenerate

   logic [2:0] level_s;
   logic       start;
   coin_e      coin_now;
   coin_e      shown;
   logic [3:0] digit [2];
   logic [6:0] seg   [2];

   coin_level_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .raw_i(level_i), .sync_o(level_s), .rise0_o(start)
   );

   assign coin_now = coin_from_level(level_s);

   coin_seq_ctrl #(.HOLD_CYC(HOLD_CYC), .CLR_CYC(CLR_CYC)) u_ctrl (
      .clk(clk), .rst(rst), .start_i(start), .coin_i(coin_now),
      .shown_o(shown), .busy_o(busy), .clr_o(peak_clr)
   );

   always_comb begin
      case (shown)
         COIN_NICKEL:  begin digit[1] = 4'd0; digit[0] = 4'd5; end
         COIN_DIME:    begin digit[1] = 4'd1; digit[0] = 4'd0; end
         COIN_QUARTER: begin digit[1] = 4'd2; digit[0] = 4'd5; end
         default:      begin digit[1] = 4'd0; digit[0] = 4'd0; end
      endcase
   end

   generate
      for (genvar d = 0; d < 2; d++) begin : g_digit
         coin_seg_enc u_enc (.bcd_i(digit[d]), .seg_n_o(seg[d]));
      end
   endgenerate

   assign bcd_tens    = digit[1];
   assign bcd_units   = digit[0];
   assign seg_tens_n  = seg[1];
   assign seg_units_n = seg[0];
endmodule

// File: rtl/coin_display_seq_chk.sv
module coin_display_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic [3:0] bcd_tens,
   input logic [3:0] bcd_units,
   input logic [6:0] seg_tens_n,
   input logic [6:0] seg_units_n,
   input logic       busy,
   input logic       peak_clr
);
   AST_CLR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      peak_clr |-> busy);                                              // R8
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (bcd_tens == 4'd0 && bcd_units == 4'd0));              // R7
   AST_BUSY_VALUE: assert property (@(posedge clk) disable iff (rst)
      busy |-> ({bcd_tens, bcd_units} == 8'h05 || {bcd_tens, bcd_units} == 8'h10
                || {bcd_tens, bcd_units} == 8'h25));                   // R2
   AST_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> ({bcd_tens, bcd_units} >= $past({bcd_tens, bcd_units}))); // R10
   AST_CLR_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
      $rose(peak_clr) |-> $past(busy));                                // R6
   AST_END_FROM_CLR: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(peak_clr));                                // R7
   AST_IDLE_SEGS: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (seg_tens_n == 7'h40 && seg_units_n == 7'h40));        // R11
endmodule

bind coin_display_seq coin_display_seq_chk u_chk (
   .clk(clk), .rst(rst), .bcd_tens(bcd_tens), .bcd_units(bcd_units),
   .seg_tens_n(seg_tens_n), .seg_units_n(seg_units_n),
   .busy(busy), .peak_clr(peak_clr)
);

// File: tb/coin_display_seq_bench.sv
module coin_display_seq_bench;
   localparam int HOLD = 30;   // 10 cycles per ms x 3 ms
   localparam int CLR  = 20;   // 10 cycles per ms x 2 ms

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] level_i = 3'b000;
   logic [3:0] bcd_tens, bcd_units;
   logic [6:0] seg_tens_n, seg_units_n;
   logic       busy, peak_clr;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   coin_display_seq #(.CLK_HZ(10_000), .HOLD_MS(3), .CLR_MS(2)) u_coin_display_seq (
      .clk(clk), .rst(rst), .level_i(level_i),
      .bcd_tens(bcd_tens), .bcd_units(bcd_units),
      .seg_tens_n(seg_tens_n), .seg_units_n(seg_units_n),
      .busy(busy), .peak_clr(peak_clr)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] seg_of(input int d);
      case (d)
         0: return 7'h40;
         1: return 7'h79;
         2: return 7'h24;
         5: return 7'h12;
         default: return 7'h7F;
      endcase
   endfunction

   task automatic settle_idle();
      level_i = 3'b000;
      repeat (6) @(negedge clk);
   endtask

   // drive a level at a negedge and follow the full sequence
   task automatic run_coin(input logic [2:0] lvl, input int t, input int u, input string req);
      int bad_hold = 0, bad_clr = 0;
      @(negedge clk);
      level_i = lvl;
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R4 latency", busy, 0);
      for (int i = 0; i < HOLD; i++) begin
         @(negedge clk);
         if (!(busy && !peak_clr && bcd_tens == t && bcd_units == u)) bad_hold++;
      end
      check(bad_hold == 0, {req, " R5 hold"}, bad_hold, 0);
      check(seg_tens_n == seg_of(t) && seg_units_n == seg_of(u), "R11 segments",
            {seg_tens_n, 1'b0, seg_units_n}, {seg_of(t), 1'b0, seg_of(u)});
      for (int i = 0; i < CLR; i++) begin
         @(negedge clk);
         if (!(busy && peak_clr && bcd_tens == t && bcd_units == u)) bad_clr++;
      end
      check(bad_clr == 0, {req, " R6 clear"}, bad_clr, 0);
      @(negedge clk);
      check(!busy && !peak_clr && bcd_tens == 0 && bcd_units == 0, "R7 end",
            {busy, peak_clr, bcd_tens, bcd_units}, 0);
   endtask

   task automatic test_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy && !peak_clr && bcd_tens == 0 && bcd_units == 0 &&
            seg_tens_n == 7'h40 && seg_units_n == 7'h40, "R1 reset",
            {busy, peak_clr, bcd_tens, bcd_units}, 0);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic test_held_level();
      // level stays 001 after the sequence: no new start
      int seen = 0;
      run_coin(3'b001, 0, 5, "R2 nickel");
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (busy) seen++;
      end
      check(seen == 0, "R4 held level", seen, 0);
      settle_idle();
   endtask

   task automatic test_no_trigger();
      int seen = 0;
      @(negedge clk);
      level_i = 3'b110;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (busy) seen++;
      end
      check(seen == 0, "R4 R3 code 110 no start", seen, 0);
      settle_idle();
   endtask

   task automatic test_settling();
      // 001 then 011 then 111 then back to 001 during hold
      @(negedge clk);
      level_i = 3'b001;
      repeat (3) @(negedge clk);
      check(busy && bcd_units == 5 && bcd_tens == 0, "R10 first", {bcd_tens, bcd_units}, 8'h05);
      level_i = 3'b011;
      repeat (4) @(negedge clk);
      check(bcd_tens == 1 && bcd_units == 0, "R10 rise dime", {bcd_tens, bcd_units}, 8'h10);
      level_i = 3'b111;
      repeat (4) @(negedge clk);
      check(bcd_tens == 2 && bcd_units == 5, "R10 rise quarter", {bcd_tens, bcd_units}, 8'h25);
      level_i = 3'b001;
      repeat (HOLD - 8) @(negedge clk);
      check(busy && peak_clr && bcd_tens == 2 && bcd_units == 5, "R10 kept max",
            {peak_clr, bcd_tens, bcd_units}, 12'h125);
      repeat (CLR) @(negedge clk);
      check(!busy, "R7 settling end", busy, 0);
      settle_idle();
   endtask

   task automatic test_retrigger();
      int len = 0;
      @(negedge clk);
      level_i = 3'b011;
      repeat (3) @(negedge clk);
      len = 1;
      repeat (4) @(negedge clk);
      len += 4;
      level_i = 3'b000;
      repeat (3) @(negedge clk);
      len += 3;
      level_i = 3'b011;
      while (busy && len < 1000) begin
         @(negedge clk);
         if (busy) len++;
      end
      check(len == HOLD + CLR, "R9 R8 no restart", len, HOLD + CLR);
      settle_idle();
   endtask

   initial begin
      #(20ns * 100_000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      test_reset();
      test_held_level();
      run_coin(3'b011, 1, 0, "R2 dime");
      settle_idle();
      run_coin(3'b111, 2, 5, "R2 quarter");
      settle_idle();
      run_coin(3'b101, 0, 5, "R3 code 101");
      settle_idle();
      test_no_trigger();
      test_settling();
      test_retrigger();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule